// File: doc/BRIEF.md
# Register-Window AXI4-Lite Master Bridge

This block gives a narrow 16-bit register bus access to a 32-bit AXI4-Lite target. Software fills a 32-bit target address, and for writes a 32-bit data word, in two 16-bit halves each. It then writes a command code into the control register. The bridge runs one AXI4-Lite transaction and captures read data into a pair of 16-bit registers. The outcome is recorded in sticky event bits of the status register.

Each event bit (read done, write done, timeout, error, external interrupt) is armed by its own enable bit in the control register. The interrupt output is raised while any armed event is pending. The command variants with post-increment step the stored address by one 32-bit word after a successful transfer, so a driver can walk a region without reloading the address. A cycle counter abandons a transaction when the target does not respond, and the bridge then returns to idle.

Top module: `axb_regbus_axil_master`

## Requirements
- R1: The register bus selects one of eight 16-bit words by rb_addr: 0 status, 1 control, 2 address low, 3 address high, 4 write data low, 5 write data high, 6 read data low, 7 read data high. A transfer drives AXI address {word 3, word 2} and write data {word 5, word 4}, with all byte strobes set.
- R2: A successful read places rdata[15:0] in word 6 and rdata[31:16] in word 7 and sets status bit 7. Bit 7 is cleared when the next command is accepted.
- R3: Control bits 3:0 select the command. 0x8 is a write, 0x9 a write with post-increment, 0xA a read and 0xB a read with post-increment; each starts exactly one AXI transaction. Any other code, 0x0 included, starts nothing.
- R4: Status bit 6 (busy) is high from the clock edge that accepts a command until the edge of the response handshake. A command written while busy is ignored: it causes no AXI transaction and no event.
- R5: Status bits 15 (read done), 14 (write done), 13 (timeout), 12 (error) and 11 (external interrupt) are sticky. Writing 1 to one of them in word 0 clears it, writing 0 leaves it unchanged, and a new event in the same cycle wins over the clear.
- R6: Control bits 15..11 enable the events of status bits 15..11, bit for bit. An event whose enable is clear is never recorded. Word 1 reads back the enables in bits 15:11 and zero elsewhere.
- R7: A BRESP or RRESP other than 0 (OKAY) sets status bit 12 and no completion bit, and leaves words 6 and 7 unchanged.
- R8: If no response arrives within TIMEOUT_CYCLES busy cycles, status bit 13 is set. The valid signals are dropped, busy falls and no completion bit is set.
- R9: The post-increment commands add 4 to the 32-bit address held in words 3:2, carrying from the low half into the high half, and only after an OKAY response.
- R10: Status bit 5 is low until INIT_CYCLES clock edges after reset release and stays high afterwards.
- R11: ext_irq high at a clock edge sets status bit 11 when enabled. irq_o is high exactly when some event bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rb_sel | input | 1 | Register bus select |
| rb_we | input | 1 | Register bus write strobe (with rb_sel) |
| rb_addr | input | 3 | Register word index |
| rb_wdata | input | 16 | Register write data |
| rb_rdata | output | 16 | Register read data (combinational) |
| ext_irq | input | 1 | Interrupt request from the AXI side |
| irq_o | output | 1 | Interrupt output |
| m_awaddr | output | 32 | AXI write address |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | AXI write data |
| m_wstrb | output | 4 | Write byte strobes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | 32 | AXI read address |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 32 | AXI read data |
| m_rresp | input | 2 | Read response code |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
Writes and reads run against a responding target model with several data words and addresses. Two read sources are used, a location written earlier and a location still holding its reset pattern, so a swapped half or a stale capture shows up. The post-increment commands use an address whose low half is 0xFFFC, which separates a correct carry into the high half from a 16-bit wrap. A target that answers SLVERR tells the error path apart from completion, and a silent target checks the timeout window. Further patterns cover undefined command codes, a command issued while busy, cleared enables and write-zero clears; each must leave the bus idle or the flags untouched.

// File: rtl/axb_pkg.sv
package axb_pkg;
   // register word indices; software depends on this order
   localparam logic [2:0] REG_STAT = 3'd0;
   localparam logic [2:0] REG_CTRL = 3'd1;
   localparam logic [2:0] REG_ALO  = 3'd2;
   localparam logic [2:0] REG_AHI  = 3'd3;
   localparam logic [2:0] REG_WLO  = 3'd4;
   localparam logic [2:0] REG_WHI  = 3'd5;
   localparam logic [2:0] REG_RLO  = 3'd6;
   localparam logic [2:0] REG_RHI  = 3'd7;

   localparam logic [3:0] CMD_WR     = 4'h8;
   localparam logic [3:0] CMD_WR_INC = 4'h9;
   localparam logic [3:0] CMD_RD     = 4'hA;
   localparam logic [3:0] CMD_RD_INC = 4'hB;

   // event vector index (status bit = 11 + index)
   localparam int EV_N   = 5;
   localparam int EV_LSB = 11;

   typedef enum logic [1:0] {
      XS_IDLE  = 2'd0,
      XS_WRITE = 2'd1,
      XS_READ  = 2'd2
   } xfer_state_e;
endpackage

// File: rtl/axb_xfer_engine.sv
module axb_xfer_engine #(
   parameter int AW             = 32,
   parameter int DW             = 32,
   parameter int TIMEOUT_CYCLES = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_rd,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic          busy,
   output logic          done_rd_ok,
   output logic          done_wr_ok,
   output logic          done_err,
   output logic          done_tmo,
   output logic [AW-1:0] m_awaddr,
   output logic          m_awvalid,
   input  logic          m_awready,
   output logic [DW-1:0] m_wdata,
   output logic [DW/8-1:0] m_wstrb,
   output logic          m_wvalid,
   input  logic          m_wready,
   input  logic [1:0]    m_bresp,
   input  logic          m_bvalid,
   output logic          m_bready,
   output logic [AW-1:0] m_araddr,
   output logic          m_arvalid,
   input  logic          m_arready,
   input  logic [1:0]    m_rresp,
   input  logic          m_rvalid,
   output logic          m_rready
);
   import axb_pkg::*;

   localparam int CW = $clog2(TIMEOUT_CYCLES + 1);

   if (TIMEOUT_CYCLES < 2) begin : g_bad_tmo
      $error("TIMEOUT_CYCLES must be at least 2");
   end
   if (DW % 8 != 0) begin : g_bad_dw
      $error("DW must be a whole number of bytes");
   end

   xfer_state_e   st_q;
   logic          aw_done_q, w_done_q, ar_done_q;
   logic [CW-1:0] cnt_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;

   logic in_wr, in_rd;
   logic aw_fire, w_fire, ar_fire, b_fire, r_fire, resp_fire, expire;

   assign in_wr = (st_q == XS_WRITE);
   assign in_rd = (st_q == XS_READ);
   assign busy  = (st_q != XS_IDLE);

   assign m_awaddr  = addr_q;
   assign m_araddr  = addr_q;
   assign m_wdata   = wdata_q;
   assign m_wstrb   = '1;
   assign m_awvalid = in_wr && !aw_done_q;
   assign m_wvalid  = in_wr && !w_done_q;
   assign m_bready  = in_wr && aw_done_q && w_done_q;
   assign m_arvalid = in_rd && !ar_done_q;
   assign m_rready  = in_rd && ar_done_q;

   assign aw_fire   = m_awvalid && m_awready;
   assign w_fire    = m_wvalid && m_wready;
   assign ar_fire   = m_arvalid && m_arready;
   assign b_fire    = m_bready && m_bvalid;
   assign r_fire    = m_rready && m_rvalid;
   assign resp_fire = b_fire || r_fire;
   assign expire    = busy && !resp_fire && (cnt_q == CW'(TIMEOUT_CYCLES - 1));

   assign done_wr_ok = b_fire && (m_bresp == 2'b00);
   assign done_rd_ok = r_fire && (m_rresp == 2'b00);
   assign done_err   = (b_fire && (m_bresp != 2'b00)) || (r_fire && (m_rresp != 2'b00));
   assign done_tmo   = expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= XS_IDLE;
         aw_done_q <= 1'b0;
         w_done_q  <= 1'b0;
         ar_done_q <= 1'b0;
         cnt_q     <= '0;
         addr_q    <= '0;
         wdata_q   <= '0;
      end else begin
         case (st_q)
            XS_IDLE: begin
               if (start) begin
                  st_q      <= start_rd ? XS_READ : XS_WRITE;
                  addr_q    <= addr;
                  wdata_q   <= wdata;
                  aw_done_q <= 1'b0;
                  w_done_q  <= 1'b0;
                  ar_done_q <= 1'b0;
                  cnt_q     <= '0;
               end
            end
            default: begin
               if (aw_fire) aw_done_q <= 1'b1;
               if (w_fire)  w_done_q  <= 1'b1;
               if (ar_fire) ar_done_q <= 1'b1;
               cnt_q <= cnt_q + 1'b1;
               if (resp_fire || expire) st_q <= XS_IDLE;
            end
         endcase
      end
   end

   // R8: the window counter never passes its limit while busy
   p_tmo_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q < CW'(TIMEOUT_CYCLES)));

   // R7: one outcome per transaction at most
   p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_rd_ok, done_wr_ok, done_err, done_tmo}));

   // R4: no request channel active while idle
   p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(m_awvalid || m_wvalid || m_arvalid || m_bready || m_rready));

   // R3: a pending address stays offered until accepted or abandoned
   p_aw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (m_awvalid && !m_awready && !expire) |=> (m_awvalid && $stable(m_awaddr)));

   p_ar_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (m_arvalid && !m_arready && !expire) |=> (m_arvalid && $stable(m_araddr)));
endmodule

// File: rtl/axb_event_flags.sv
module axb_event_flags #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hit,
   input  logic [N-1:0] en,
   input  logic [N-1:0] clr,
   output logic [N-1:0] ev_q
);
   if (N < 1) begin : g_bad_n
      $error("N must be positive");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic bit_q;
      logic set_i;
      assign set_i = hit[i] && en[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bit_q <= 1'b0;
         else        bit_q <= set_i || (bit_q && !clr[i]);
      end
      assign ev_q[i] = bit_q;

      // R5: a cleared flag without a new event reads zero next cycle
      p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set_i) |=> !bit_q);
      // R5: a flag without a clear stays set
      p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (bit_q && !clr[i]) |=> bit_q);
      // R6: a disabled flag never rises
      p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (!bit_q && !en[i]) |=> !bit_q);
   end
endmodule

// File: rtl/axb_regbus_axil_master.sv
module axb_regbus_axil_master #(
   parameter int RB_W           = 16,
   parameter int AX_W           = 32,
   parameter int TIMEOUT_CYCLES = 256,
   parameter int INIT_CYCLES    = 16,
   parameter bit IRQ_REG        = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rb_sel,
   input  logic            rb_we,
   input  logic [2:0]      rb_addr,
   input  logic [RB_W-1:0] rb_wdata,
   output logic [RB_W-1:0] rb_rdata,
   input  logic            ext_irq,
   output logic            irq_o,
   output logic [AX_W-1:0] m_awaddr,
   output logic            m_awvalid,
   input  logic            m_awready,
   output logic [AX_W-1:0] m_wdata,
   output logic [AX_W/8-1:0] m_wstrb,
   output logic            m_wvalid,
   input  logic            m_wready,
   input  logic [1:0]      m_bresp,
   input  logic            m_bvalid,
   output logic            m_bready,
   output logic [AX_W-1:0] m_araddr,
   output logic            m_arvalid,
   input  logic            m_arready,
   input  logic [AX_W-1:0] m_rdata,
   input  logic [1:0]      m_rresp,
   input  logic            m_rvalid,
   output logic            m_rready
);
   import axb_pkg::*;

   localparam int ICW      = $clog2(INIT_CYCLES + 1);
   localparam int WORD_B   = AX_W / 8;

   if (AX_W != 2 * RB_W) begin : g_bad_width
      $error("AX_W must be twice RB_W");
   end
   if (RB_W < EV_LSB + EV_N) begin : g_bad_rbw
      $error("RB_W too narrow for the event field");
   end
   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("INIT_CYCLES must be positive");
   end

   // ---------------- register bus decode ----------------
   logic wr_any, wr_stat, wr_ctrl;
   logic [3:0] cmd;
   logic cmd_ok, start;

   assign wr_any  = rb_sel && rb_we;
   assign wr_stat = wr_any && (rb_addr == REG_STAT);
   assign wr_ctrl = wr_any && (rb_addr == REG_CTRL);
   assign cmd     = rb_wdata[3:0];
   assign cmd_ok  = (cmd == CMD_WR) || (cmd == CMD_WR_INC) ||
                    (cmd == CMD_RD) || (cmd == CMD_RD_INC);

   // ---------------- state ----------------
   logic [EV_N-1:0] en_q;
   logic [AX_W-1:0] addr_q, wd_q, rd_q;
   logic            rdav_q, inc_q, init_q;
   logic [ICW-1:0]  init_cnt_q;

   logic busy, done_rd_ok, done_wr_ok, done_err, done_tmo, done_ok;
   logic [EV_N-1:0] ev_q, ev_hit, ev_clr;

   assign start   = wr_ctrl && cmd_ok && !busy;
   assign done_ok = done_rd_ok || done_wr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         addr_q <= '0;
         wd_q   <= '0;
         rd_q   <= '0;
         rdav_q <= 1'b0;
         inc_q  <= 1'b0;
      end else begin
         if (wr_ctrl) en_q <= rb_wdata[EV_LSB +: EV_N];
         if (wr_any && rb_addr == REG_ALO) addr_q[RB_W-1:0]    <= rb_wdata;
         if (wr_any && rb_addr == REG_AHI) addr_q[AX_W-1:RB_W] <= rb_wdata;
         if (wr_any && rb_addr == REG_WLO) wd_q[RB_W-1:0]      <= rb_wdata;
         if (wr_any && rb_addr == REG_WHI) wd_q[AX_W-1:RB_W]   <= rb_wdata;
         if (done_ok && inc_q) addr_q <= addr_q + AX_W'(WORD_B);
         if (start) begin
            inc_q  <= rb_wdata[0];
            rdav_q <= 1'b0;
         end
         if (done_rd_ok) begin
            rd_q   <= m_rdata;
            rdav_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_cnt_q <= '0;
         init_q     <= 1'b0;
      end else if (!init_q) begin
         init_cnt_q <= init_cnt_q + 1'b1;
         if (init_cnt_q == ICW'(INIT_CYCLES - 1)) init_q <= 1'b1;
      end
   end

   // ---------------- transfer engine ----------------
   axb_xfer_engine #(
      .AW(AX_W), .DW(AX_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
   ) u_xfer (
      .clk(clk), .rst_n(rst_n),
      .start(start), .start_rd(cmd[1]),
      .addr(addr_q), .wdata(wd_q),
      .busy(busy),
      .done_rd_ok(done_rd_ok), .done_wr_ok(done_wr_ok),
      .done_err(done_err), .done_tmo(done_tmo),
      .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
      .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
      .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
      .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(m_arready),
      .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
   );

   // ---------------- event flags ----------------
   assign ev_hit = {done_rd_ok, done_wr_ok, done_tmo, done_err, ext_irq};
   assign ev_clr = wr_stat ? rb_wdata[EV_LSB +: EV_N] : '0;

   axb_event_flags #(.N(EV_N)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .hit(ev_hit), .en(en_q), .clr(ev_clr),
      .ev_q(ev_q)
   );

   // ---------------- interrupt ----------------
   logic irq_any;
   assign irq_any = |(ev_q & en_q);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_any;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_any;
      // R11: the output only rises with a pending event
      p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> (ev_q != '0));
   end

   // ---------------- read mux ----------------
   always_comb begin
      rb_rdata = '0;
      case (rb_addr)
         REG_STAT: begin
            rb_rdata[EV_LSB +: EV_N] = ev_q;
            rb_rdata[7] = rdav_q;
            rb_rdata[6] = busy;
            rb_rdata[5] = init_q;
         end
         REG_CTRL: rb_rdata[EV_LSB +: EV_N] = en_q;
         REG_ALO:  rb_rdata = addr_q[RB_W-1:0];
         REG_AHI:  rb_rdata = addr_q[AX_W-1:RB_W];
         REG_WLO:  rb_rdata = wd_q[RB_W-1:0];
         REG_WHI:  rb_rdata = wd_q[AX_W-1:RB_W];
         REG_RLO:  rb_rdata = rd_q[RB_W-1:0];
         REG_RHI:  rb_rdata = rd_q[AX_W-1:RB_W];
         default:  rb_rdata = '0;
      endcase
   end

   // R10: ready flag never drops once set
   p_init_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      init_q |=> init_q);

   // R9: successful post-increment steps the stored address by one word
   p_postinc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_ok && inc_q) |=> (addr_q == $past(addr_q) + AX_W'(WORD_B)));

   // R2: a good read raises the data-available flag
   p_rdav_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_rd_ok |=> rdav_q);

   // R4: a command accepted makes the bridge busy on the next cycle
   p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
endmodule

// File: tb/sim_axb_regbus_axil_master.sv
`timescale 1ns/1ps
module sim_axb_regbus_axil_master;
   localparam int TMO  = 40;
   localparam int INIT = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        rb_sel = 1'b0, rb_we = 1'b0;
   logic [2:0]  rb_addr = 3'd0;
   logic [15:0] rb_wdata = 16'h0;
   logic [15:0] rb_rdata;
   logic        ext_irq = 1'b0;
   logic        irq_o;
   logic [31:0] m_awaddr, m_wdata, m_araddr, m_rdata;
   logic [3:0]  m_wstrb;
   logic        m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
   logic        m_bvalid, m_rvalid;
   logic [1:0]  m_bresp, m_rresp;

   axb_regbus_axil_master #(.TIMEOUT_CYCLES(TMO), .INIT_CYCLES(INIT)) u0 (
      .clk(clk), .rst_n(rst_n),
      .rb_sel(rb_sel), .rb_we(rb_we), .rb_addr(rb_addr), .rb_wdata(rb_wdata), .rb_rdata(rb_rdata),
      .ext_irq(ext_irq), .irq_o(irq_o),
      .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(1'b1),
      .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(1'b1),
      .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
      .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(1'b1),
      .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
   );

   // ---------------- target model ----------------
   logic        sl_mute = 1'b0, sl_flush = 1'b0;
   logic [1:0]  sl_resp = 2'b00;
   int          sl_lat = 2;
   logic [31:0] mem [0:15];
   logic        got_aw, got_w, rpend;
   int          wcnt, rcnt, aw_cnt, ar_cnt;
   logic [31:0] last_awaddr, last_wdata, last_araddr;
   logic [3:0]  last_wstrb;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mem[i] <= 32'h1000_0000 | i;
         got_aw <= 0; got_w <= 0; rpend <= 0; wcnt <= 0; rcnt <= 0;
         aw_cnt <= 0; ar_cnt <= 0; m_bvalid <= 0; m_rvalid <= 0;
         m_bresp <= 0; m_rresp <= 0; m_rdata <= 0;
         last_awaddr <= 0; last_wdata <= 0; last_araddr <= 0; last_wstrb <= 0;
      end else if (sl_flush) begin
         got_aw <= 0; got_w <= 0; rpend <= 0; wcnt <= 0; rcnt <= 0;
      end else begin
         if (m_awvalid) begin got_aw <= 1; last_awaddr <= m_awaddr; aw_cnt <= aw_cnt + 1; end
         if (m_wvalid)  begin got_w <= 1; last_wdata <= m_wdata; last_wstrb <= m_wstrb; end
         if (got_aw && got_w && !m_bvalid && !sl_mute) begin
            if (wcnt >= sl_lat) begin
               m_bvalid <= 1; m_bresp <= sl_resp;
               if (sl_resp == 2'b00) mem[last_awaddr[5:2]] <= last_wdata;
               got_aw <= 0; got_w <= 0; wcnt <= 0;
            end else wcnt <= wcnt + 1;
         end
         if (m_bvalid && m_bready) m_bvalid <= 0;
         if (m_arvalid) begin rpend <= 1; last_araddr <= m_araddr; ar_cnt <= ar_cnt + 1; end
         if (rpend && !m_rvalid && !sl_mute) begin
            if (rcnt >= sl_lat) begin
               m_rvalid <= 1; m_rresp <= sl_resp; m_rdata <= mem[last_araddr[5:2]];
               rpend <= 0; rcnt <= 0;
            end else rcnt <= rcnt + 1;
         end
         if (m_rvalid && m_rready) m_rvalid <= 0;
      end
   end

   // ---------------- bench helpers ----------------
   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      rb_sel = 1; rb_we = 1; rb_addr = a; rb_wdata = d;
      @(negedge clk);
      rb_sel = 0; rb_we = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      rb_addr = a; #1; d = rb_rdata;
   endtask

   task automatic rd32(input logic [2:0] lo, output logic [31:0] d);
      logic [15:0] l, h;
      rd(lo, l); rd(lo + 3'd1, h); d = {h, l};
   endtask

   task automatic set_addr(input logic [31:0] a);
      wr(3'd2, a[15:0]); wr(3'd3, a[31:16]);
   endtask

   task automatic wait_idle(output int n);
      logic [15:0] s;
      n = 0; rd(3'd0, s);
      while (s[6] && n < 2000) begin @(negedge clk); n++; rd(3'd0, s); end
   endtask

   task automatic clear_all;
      wr(3'd0, 16'hF800);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      logic [15:0] s;
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      rd(3'd0, s); chk("R10 status after reset", s, 16'h0000);
      rd(3'd1, s); chk("R6 control after reset", s, 16'h0000);
      rd(3'd6, s); chk("R2 read data low after reset", s, 16'h0000);
      chk("R11 irq after reset", irq_o, 0);
      chk("R4 no request after reset", {m_awvalid, m_arvalid}, 2'b00);
      repeat (INIT - 1) @(negedge clk);
      rd(3'd0, s); chk("R10 init low one edge early", s[5], 0);
      @(negedge clk);
      rd(3'd0, s); chk("R10 init high on time", s[5], 1);
   endtask

   task automatic t_write_basic;
      logic [15:0] s; int n;
      sl_lat = 3;
      set_addr(32'h0000_0010);
      wr(3'd4, 16'hBEEF); wr(3'd5, 16'hDEAD);
      wr(3'd1, 16'hF808);
      rd(3'd0, s); chk("R4 busy after accept", s[6], 1);
      wait_idle(n);
      chk("R1 AXI write address", last_awaddr, 32'h0000_0010);
      chk("R1 AXI write data", last_wdata, 32'hDEAD_BEEF);
      chk("R1 byte strobes", last_wstrb, 4'hF);
      rd(3'd0, s); chk("R5 write done only", s & 16'hF800, 16'h4000);
      chk("R11 irq with armed event", irq_o, 1);
      rd(3'd1, s); chk("R6 enables readback", s, 16'hF800);
      wr(3'd0, 16'h0000);
      rd(3'd0, s); chk("R5 write zero keeps flag", s[14], 1);
      wr(3'd0, 16'h4000);
      rd(3'd0, s); chk("R5 write one clears flag", s[14], 0);
      chk("R11 irq drops after clear", irq_o, 0);
   endtask

   task automatic t_read_basic;
      logic [15:0] s; logic [31:0] d; int n;
      set_addr(32'h0000_0010);
      wr(3'd1, 16'hF80A);
      wait_idle(n);
      chk("R3 read address", last_araddr, 32'h0000_0010);
      rd32(3'd6, d); chk("R2 read back written word", d, 32'hDEAD_BEEF);
      rd(3'd0, s); chk("R2 data available and read done", s & 16'hF880, 16'h8080);
      clear_all;
      set_addr(32'h0000_0024);
      wr(3'd1, 16'hF80A);
      rd(3'd0, s); chk("R2 data available cleared at accept", s[7], 0);
      wait_idle(n);
      rd32(3'd6, d); chk("R2 read of reset pattern", d, 32'h1000_0009);
      clear_all;
   endtask

   task automatic t_postinc;
      logic [31:0] a; logic [15:0] s; int n;
      set_addr(32'h0001_FFFC);
      wr(3'd4, 16'h5678); wr(3'd5, 16'h1234);
      wr(3'd1, 16'hF809);
      wait_idle(n);
      chk("R3 write-inc address used", last_awaddr, 32'h0001_FFFC);
      rd32(3'd2, a); chk("R9 carry into high half", a, 32'h0002_0000);
      wr(3'd1, 16'hF80B);
      wait_idle(n);
      chk("R3 read-inc address used", last_araddr, 32'h0002_0000);
      rd32(3'd2, a); chk("R9 read-inc step", a, 32'h0002_0004);
      rd(3'd0, s); chk("R9 read done flag", s[15], 1);
      clear_all;
   endtask

   task automatic t_bad_cmd;
      logic [15:0] s; int aw0, ar0;
      aw0 = aw_cnt; ar0 = ar_cnt;
      wr(3'd1, 16'hF800);
      rd(3'd0, s); chk("R3 nop not busy", s[6], 0);
      wr(3'd1, 16'hF805);
      rd(3'd0, s); chk("R3 code 5 not busy", s[6], 0);
      wr(3'd1, 16'hF80C);
      repeat (4) @(negedge clk);
      chk("R3 no transaction for bad codes", aw_cnt + ar_cnt, aw0 + ar0);
      rd(3'd0, s); chk("R3 no event for bad codes", s & 16'hF800, 16'h0000);
   endtask

   task automatic t_busy_ignore;
      logic [15:0] s; logic [31:0] d; int n, aw0;
      sl_lat = 10;
      aw0 = aw_cnt;
      set_addr(32'h0000_0024);
      wr(3'd1, 16'hF80A);
      wr(3'd1, 16'hF808);
      wait_idle(n);
      repeat (4) @(negedge clk);
      chk("R4 command while busy ignored", aw_cnt, aw0);
      rd(3'd0, s); chk("R4 only the read completed", s & 16'hF800, 16'h8000);
      rd32(3'd6, d); chk("R4 read data intact", d, 32'h1000_0009);
      clear_all;
      sl_lat = 2;
   endtask

   task automatic t_gate;
      logic [15:0] s; int n;
      set_addr(32'h0000_0030);
      wr(3'd1, 16'h0008);
      wait_idle(n);
      rd(3'd0, s); chk("R6 disabled write done not recorded", s & 16'hF800, 16'h0000);
      chk("R6 no irq when disabled", irq_o, 0);
      rd(3'd1, s); chk("R6 enables cleared", s, 16'h0000);
   endtask

   task automatic t_error;
      logic [15:0] s; logic [31:0] a, d0, d1; int n;
      rd32(3'd6, d0);
      sl_resp = 2'b10;
      set_addr(32'h0000_0040);
      wr(3'd1, 16'hF809);
      wait_idle(n);
      rd(3'd0, s); chk("R7 write error flag only", s & 16'hF800, 16'h1000);
      rd32(3'd2, a); chk("R9 no increment on error", a, 32'h0000_0040);
      clear_all;
      wr(3'd1, 16'hF80B);
      wait_idle(n);
      rd(3'd0, s); chk("R7 read error flags", s & 16'hF880, 16'h1000);
      rd32(3'd6, d1); chk("R7 read data unchanged", d1, d0);
      rd32(3'd2, a); chk("R9 no increment on read error", a, 32'h0000_0040);
      sl_resp = 2'b00;
      clear_all;
   endtask

   task automatic t_timeout;
      logic [15:0] s; int n;
      sl_mute = 1;
      set_addr(32'h0000_0008);
      wr(3'd1, 16'hF80A);
      wait_idle(n);
      n_chk++;
      if (n < TMO - 2 || n > TMO + 2) begin
         n_fail++;
         $display("FAIL R8 timeout window act=%0d exp=%0d", n, TMO);
      end
      rd(3'd0, s); chk("R8 timeout flag only", s & 16'hF800, 16'h2000);
      chk("R8 read request dropped", m_arvalid, 0);
      sl_mute = 0;
      @(negedge clk); sl_flush = 1;
      @(negedge clk); sl_flush = 0;
      clear_all;
   endtask

   task automatic t_ext_irq;
      logic [15:0] s;
      wr(3'd1, 16'h0800);
      @(negedge clk); ext_irq = 1;
      @(negedge clk); ext_irq = 0;
      rd(3'd0, s); chk("R11 external interrupt flag", s[11], 1);
      chk("R11 irq output", irq_o, 1);
      wr(3'd0, 16'h0800);
      chk("R11 irq cleared", irq_o, 0);
      wr(3'd1, 16'h0000);
      @(negedge clk); ext_irq = 1;
      @(negedge clk); ext_irq = 0;
      rd(3'd0, s); chk("R6 disabled external interrupt", s[11], 0);
      chk("R11 no irq when disabled", irq_o, 0);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_write_basic();
      t_read_basic();
      t_postinc();
      t_bad_cmd();
      t_busy_ignore();
      t_error();
      t_timeout();
      t_ext_irq();
      t_gate();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule